// File: doc/BRIEF.md
# BCD 24-Hour Timekeeping Core with Hourly Chime

This block keeps the time of day as three packed BCD words: seconds, minutes and hours. A single-cycle enable, `tick_1hz`, arrives once per second in the system clock domain. Each tick advances the seconds. When the seconds wrap from 59 to 00 they carry into the minutes. When the minutes wrap they carry into the hours, and the hours cycle through 00 to 23. No derived clocks are used: every register runs on `clk` and changes only on a tick.

Two active-low adjust inputs let the time be set by hand. While `set_min_n` is low, the minute stage takes every tick in place of the seconds carry. While `set_hr_n` is low, the hour stage does the same in place of the minute carry. An adjusted stage still wraps at its own limit, but it passes no carry to the next stage. An active-low synchronous clear, `clr_n`, overrides everything. The `chime` output is a registered flag. It is high for the whole second in which both minutes and seconds read 00, which marks the top of each hour.

Top module: `bcd_clock24`

## Requirements
- R1: Each time word is 7-bit packed BCD, with the tens digit in bits 6:4 and the units digit in bits 3:0. Counters change only on clock edges where `tick_1hz` is 1, or where the clear is active.
- R2: On each tick, seconds advance from 00 to 59 in BCD. From 59 they return to 00 and issue a carry to the minute stage during that same tick.
- R3: With both adjust inputs high, minutes advance by one on the seconds carry and run from 00 to 59. From 59 they return to 00 and carry to the hour stage during that same tick.
- R4: Hours run from 00 to 23 and then return to 00. A single tick at 23:59:59 gives 00:00:00.
- R5: When `clr_n` is 0 at a clock edge, all three words become 00 at that edge and `chime` becomes 0. This holds whatever the values of the tick and adjust inputs.
- R6: While `set_min_n` is 0, each tick advances minutes by one. Minutes wrap from 59 to 00 and the hours do not change. Seconds keep counting normally.
- R7: While `set_hr_n` is 0, each tick advances hours by one, and hours wrap from 23 to 00.
- R8: `chime` is registered. One clock after any edge, it equals 1 if minutes and seconds were both 00 at that edge, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| tick_1hz | input | 1 | Single-cycle once-per-second enable |
| set_min_n | input | 1 | Minute adjust, active low |
| set_hr_n | input | 1 | Hour adjust, active low |
| sec_bcd | output | 7 | Seconds, packed BCD |
| min_bcd | output | 7 | Minutes, packed BCD |
| hr_bcd | output | 7 | Hours, packed BCD |
| chime | output | 1 | Top-of-hour flag |

## Verification
The properties assume that `clr_n` is held low for at least one clock edge before any other checking starts. They also assume that the adjust inputs change only in the same way as the counters, on the system clock. The stimulus satisfies both: it asserts the clear from time zero, and it changes every input at the falling clock edge. Ticks are spaced at least two clocks apart, so `chime` has settled by the time the bench compares it against its own model. Because no value outside the legal BCD range can be loaded through the ports, the assertions treat the counters as always holding legal BCD.

// File: rtl/bcd_clock24_pkg.sv
package bcd_clock24_pkg;
  localparam int UNITS_W = 4;
  localparam int TENS_W  = 3;
  localparam int WORD_W  = TENS_W + UNITS_W;

  typedef logic [WORD_W-1:0] bcd_word_t;

  // Packed BCD value formed from a tens digit and a units digit
  function automatic bcd_word_t bcd_pack(input int tens, input int units);
    bcd_word_t w;
    w = {tens[TENS_W-1:0], units[UNITS_W-1:0]};
    return w;
  endfunction
endpackage

// File: rtl/bcd_stage.sv
module bcd_stage
  import bcd_clock24_pkg::*;
#(
  parameter int WRAP_TENS  = 5,
  parameter int WRAP_UNITS = 9
) (
  input  logic      clk,
  input  logic      clr_n,
  input  logic      step,
  output logic      at_wrap,
  output bcd_word_t value
);
  localparam bcd_word_t WRAP_VAL = bcd_pack(WRAP_TENS, WRAP_UNITS);
  localparam bcd_word_t ADJ_STEP = bcd_word_t'(16 - 9);

  logic      units_nine;
  logic      out_of_range;
  bcd_word_t next_val;

  assign at_wrap      = (value == WRAP_VAL);
  assign units_nine   = (value[UNITS_W-1:0] == 4'd9);
  assign out_of_range = (value[UNITS_W-1:0] > 4'd9) || (value > WRAP_VAL);

  always_comb begin
    if (at_wrap || out_of_range) next_val = '0;
    else if (units_nine)         next_val = value + ADJ_STEP;
    else                         next_val = value + bcd_word_t'(1);
  end

  always_ff @(posedge clk) begin
    if (!clr_n)    value <= '0;
    else if (step) value <= next_val;
  end
endmodule

// File: rtl/chime_detect.sv
module chime_detect
  import bcd_clock24_pkg::*;
(
  input  logic      clk,
  input  logic      clr_n,
  input  bcd_word_t min_val,
  input  bcd_word_t sec_val,
  output logic      chime
);
  always_ff @(posedge clk) begin
    if (!clr_n) chime <= 1'b0;
    else        chime <= (min_val == '0) && (sec_val == '0);
  end
endmodule

// File: rtl/bcd_clock24.sv
module bcd_clock24
  import bcd_clock24_pkg::*;
(
  input  logic       clk,
  input  logic       clr_n,
  input  logic       tick_1hz,
  input  logic       set_min_n,
  input  logic       set_hr_n,
  output logic [6:0] sec_bcd,
  output logic [6:0] min_bcd,
  output logic [6:0] hr_bcd,
  output logic       chime
);
  logic      sec_wrap, min_wrap, hr_wrap;
  logic      sec_step, min_step, hr_step;
  bcd_word_t sec_q, min_q, hr_q;

  // Adjust steers the tick straight into a stage and blocks its onward carry
  assign sec_step = tick_1hz;
  assign min_step = tick_1hz && (!set_min_n || sec_wrap);
  assign hr_step  = tick_1hz && (!set_hr_n || (set_min_n && sec_wrap && min_wrap));

  bcd_stage #(.WRAP_TENS(5), .WRAP_UNITS(9)) sec_stage_i (
    .clk(clk), .clr_n(clr_n), .step(sec_step), .at_wrap(sec_wrap), .value(sec_q)
  );

  bcd_stage #(.WRAP_TENS(5), .WRAP_UNITS(9)) min_stage_i (
    .clk(clk), .clr_n(clr_n), .step(min_step), .at_wrap(min_wrap), .value(min_q)
  );

  bcd_stage #(.WRAP_TENS(2), .WRAP_UNITS(3)) hr_stage_i (
    .clk(clk), .clr_n(clr_n), .step(hr_step), .at_wrap(hr_wrap), .value(hr_q)
  );

  chime_detect chime_i (
    .clk(clk), .clr_n(clr_n), .min_val(min_q), .sec_val(sec_q), .chime(chime)
  );

  assign sec_bcd = sec_q;
  assign min_bcd = min_q;
  assign hr_bcd  = hr_q;
endmodule

// File: rtl/bcd_clock24_chk.sv
module bcd_clock24_chk (
  input logic       clk,
  input logic       clr_n,
  input logic       tick_1hz,
  input logic       set_min_n,
  input logic       set_hr_n,
  input logic [6:0] sec_bcd,
  input logic [6:0] min_bcd,
  input logic [6:0] hr_bcd,
  input logic       chime
);
  // R1
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !tick_1hz |=> ($stable(sec_bcd) && $stable(min_bcd) && $stable(hr_bcd)));

  // R1
  legal_bcd_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (sec_bcd[3:0] <= 4'd9) && (min_bcd[3:0] <= 4'd9) && (hr_bcd[3:0] <= 4'd9)
    && (sec_bcd <= 7'h59) && (min_bcd <= 7'h59) && (hr_bcd <= 7'h23));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (tick_1hz && sec_bcd == 7'h59) |=> (sec_bcd == 7'h00));

  // R4
  day_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (tick_1hz && set_min_n && set_hr_n && hr_bcd == 7'h23 && min_bcd == 7'h59
     && sec_bcd == 7'h59) |=> (hr_bcd == 7'h00 && min_bcd == 7'h00));

  // R5
  clear_chk: assert property (@(posedge clk)
    !clr_n |=> (sec_bcd == 7'h00 && min_bcd == 7'h00 && hr_bcd == 7'h00 && !chime));

  // R6
  set_min_keeps_hr_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (tick_1hz && !set_min_n && set_hr_n) |=> $stable(hr_bcd));

  // R7
  set_hr_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (tick_1hz && !set_hr_n && hr_bcd == 7'h23) |=> (hr_bcd == 7'h00));

  // R8
  chime_follow_chk: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (chime == $past(min_bcd == 7'h00 && sec_bcd == 7'h00)));
endmodule

bind bcd_clock24 bcd_clock24_chk chk_i (
  .clk(clk), .clr_n(clr_n), .tick_1hz(tick_1hz), .set_min_n(set_min_n),
  .set_hr_n(set_hr_n), .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hr_bcd(hr_bcd),
  .chime(chime)
);

// File: tb/bcd_clock24_tb_top.sv
module bcd_clock24_tb_top;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       set_min_n = 1'b1;
  logic       set_hr_n = 1'b1;
  logic [6:0] sec_bcd, min_bcd, hr_bcd;
  logic       chime;

  int checks = 0;
  int errors = 0;
  int m_s = 0, m_m = 0, m_h = 0;

  always #2 clk = ~clk;

  bcd_clock24 dut_i (
    .clk(clk), .clr_n(clr_n), .tick_1hz(tick_1hz), .set_min_n(set_min_n),
    .set_hr_n(set_hr_n), .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hr_bcd(hr_bcd),
    .chime(chime)
  );

  function automatic logic [6:0] to_bcd(input int n);
    logic [3:0] t, u;
    t = 4'((n / 10) % 8);
    u = 4'(n % 10);
    return {t[2:0], u};
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " sec"}, int'(sec_bcd), int'(to_bcd(m_s)));
    check({req, " min"}, int'(min_bcd), int'(to_bcd(m_m)));
    check({req, " hr"}, int'(hr_bcd), int'(to_bcd(m_h)));
    check({req, " chime"}, int'(chime), (m_m == 0 && m_s == 0) ? 1 : 0);
  endtask

  // One tick, model update, then one settle clock so chime is current
  task automatic do_tick();
    bit sc, mc;
    @(negedge clk) tick_1hz = 1'b1;
    @(negedge clk) tick_1hz = 1'b0;
    sc = (m_s == 59);
    m_s = (m_s + 1) % 60;
    mc = 1'b0;
    if (!set_min_n) m_m = (m_m + 1) % 60;
    else if (sc) begin
      mc = (m_m == 59);
      m_m = (m_m + 1) % 60;
    end
    if (!set_hr_n || mc) m_h = (m_h + 1) % 24;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R5 clear sec", int'(sec_bcd), 0);
    check("R5 clear min", int'(min_bcd), 0);
    check("R5 clear hr", int'(hr_bcd), 0);
    check("R5 clear chime", int'(chime), 0);
    clr_n = 1'b1;
    m_s = 0; m_m = 0; m_h = 0;
    @(negedge clk);
    check_all("R8 after clear");
  endtask

  task automatic t_seconds();
    for (int i = 0; i < 10; i++) do_tick();
    check("R1 R2 ten seconds", int'(sec_bcd), 'h10);
    check_all("R2 units wrap");
    for (int i = 0; i < 50; i++) do_tick();
    check("R2 wrap", int'(sec_bcd), 0);
    check("R3 carry", int'(min_bcd), 'h01);
    check_all("R3 first minute");
  endtask

  task automatic t_no_tick();
    set_min_n = 1'b0;
    set_hr_n = 1'b0;
    repeat (6) @(negedge clk);
    check_all("R1 no tick no change");
    set_min_n = 1'b1;
    set_hr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_set_min();
    set_min_n = 1'b0;
    for (int i = 0; i < 70; i++) begin
      do_tick();
      if (m_m == 0) begin
        check("R6 min wrap", int'(min_bcd), 0);
        check("R6 hr unchanged", int'(hr_bcd), 0);
      end
    end
    check_all("R6 set minutes");
    set_min_n = 1'b1;
  endtask

  task automatic t_set_hr();
    set_hr_n = 1'b0;
    for (int i = 0; i < 25; i++) begin
      do_tick();
      if (m_h == 0) check("R7 hr wrap", int'(hr_bcd), 0);
    end
    check_all("R7 set hours");
    set_hr_n = 1'b1;
  endtask

  task automatic t_rollover();
    set_hr_n = 1'b0;
    while (m_h != 23) do_tick();
    set_hr_n = 1'b1;
    set_min_n = 1'b0;
    while (m_m != 59) do_tick();
    set_min_n = 1'b1;
    while (m_s != 59) do_tick();
    check("R4 pre 23", int'(hr_bcd), 'h23);
    check_all("R4 at 23:59:59");
    do_tick();
    check("R4 day wrap hr", int'(hr_bcd), 0);
    check("R8 chime at hour", int'(chime), 1);
    check_all("R4 R8 midnight");
    do_tick();
    check("R8 chime drops", int'(chime), 0);
  endtask

  task automatic t_hour_chime();
    while (!(m_m == 59 && m_s == 59)) do_tick();
    do_tick();
    check("R3 hour carry", int'(hr_bcd), 'h01);
    check_all("R3 R8 top of hour");
  endtask

  task automatic t_clear_priority();
    for (int i = 0; i < 3; i++) do_tick();
    @(negedge clk);
    clr_n = 1'b0;
    tick_1hz = 1'b1;
    set_min_n = 1'b0;
    set_hr_n = 1'b0;
    @(negedge clk);
    check("R5 priority sec", int'(sec_bcd), 0);
    check("R5 priority min", int'(min_bcd), 0);
    check("R5 priority hr", int'(hr_bcd), 0);
    check("R5 priority chime", int'(chime), 0);
    tick_1hz = 1'b0;
    set_min_n = 1'b1;
    set_hr_n = 1'b1;
    clr_n = 1'b1;
    m_s = 0; m_m = 0; m_h = 0;
    @(negedge clk);
    check_all("R5 R8 after priority clear");
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_seconds();
    t_no_tick();
    t_set_min();
    t_set_hr();
    t_rollover();
    t_hour_chime();
    t_clear_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule